// File: doc/BRIEF.md
# Double-Buffered Auxiliary PWM Generator

This block produces a single pulse-width-modulated output from a free-running up-counter. A small register port holds a control word and four 32-bit timing registers. Two of them are live (period and compare); the other two are staging copies that are loaded into the live pair only when the counter reaches the end of its period. Software can therefore retune a running waveform without truncating or stretching the cycle that is in progress.

The counter steps from 0 to the live period value and then returns to 0, so one output cycle lasts period+1 clocks. With normal polarity the output is high while the counter is below the compare value. A control bit inverts this, so the compare value sets the low time. A mode bit gates the output: when it is clear the pin is held low. While the counter is stopped, the live registers can be written directly and take effect at once. This is how an idle channel is primed before it is started. Every register reads back, so a power-down sequence can save and restore the whole setup.

Top module: `apwm_shadow_pwm`

## Requirements
- R1: After a synchronous reset, all five registers read 0, the counter is stopped and `pwm_out` is 0.
- R2: When control bit 4 (run) is 1, the counter advances by one per clock from 0 to the live period and then returns to 0. With control bit 10 clear and bit 9 set, `pwm_out` is 1 exactly while the counter is below the live compare value. `pwm_out` is registered: it reflects counter and control values one clock earlier.
- R3: With control bit 10 set, the output level computed in R2 is inverted, so the compare value sets the low portion of each cycle.
- R4: While control bit 9 (mode) is 0, `pwm_out` is 0 on the following clock, whatever the counter does.
- R5: While run is 0, the counter keeps its value, so the output level stays frozen.
- R6: The staging period (address 3) and staging compare (address 4) are copied into the live period (address 1) and live compare (address 2) on the clock where the counter wraps, and at no other time. A cycle that is already running completes with the old values.
- R7: Writes to addresses 1 and 2 update the live registers immediately while run is 0. They are ignored while run is 1.
- R8: A live compare of 0 gives a constant low normal-polarity output. A live compare equal to or above the live period gives a constant high output.
- R9: The register map is 0 = control (16 bits, upper data bits discarded and read as 0), 1 = live period, 2 = live compare, 3 = staging period, 4 = staging compare. Addresses 5 to 7 read 0. `reg_rdata` shows the register selected by `reg_addr` one clock after the address is applied.
- R10: Control bits 7:6 (external synchronisation select) are stored and read back but do not affect the counter or the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach is a staging update that lands in the middle of a running cycle. It must stay invisible until the wrap and then change both period and compare together. The bench starts the counter with known live values and writes new staging values one and two clocks later, while the counter is still well short of the period. It then checks every output sample across the old cycle, the wrap and two new cycles. It uses the same running state to show that direct live writes are ignored and to read back which period was actually loaded.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int CTRL_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int RUN_BIT  = 4;
  localparam int MODE_BIT = 9;
  localparam int POL_BIT  = 10;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_PER    = 3'd1,
    A_CMP    = 3'd2,
    A_PER_SH = 3'd3,
    A_CMP_SH = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              wrap,
  output logic              run,
  output logic              mode,
  output logic              pol,
  output logic [CNT_W-1:0]  per_act,
  output logic [CNT_W-1:0]  cmp_act,
  output logic [CNT_W-1:0]  rdata
);
  localparam int PAD_W = CNT_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  per_sh;
  logic [CNT_W-1:0]  cmp_sh;
  logic [CNT_W-1:0]  rd_mux;

  assign run  = ctrl[RUN_BIT];
  assign mode = ctrl[MODE_BIT];
  assign pol  = ctrl[POL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      per_sh  <= '0;
      cmp_sh  <= '0;
      per_act <= '0;
      cmp_act <= '0;
    end else begin
      if (we && addr == A_CTRL)   ctrl   <= wdata[CTRL_W-1:0];
      if (we && addr == A_PER_SH) per_sh <= wdata;
      if (we && addr == A_CMP_SH) cmp_sh <= wdata;
      if (wrap) begin
        per_act <= per_sh;
        cmp_act <= cmp_sh;
      end else if (!run) begin
        if (we && addr == A_PER) per_act <= wdata;
        if (we && addr == A_CMP) cmp_act <= wdata;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rd_mux = {{PAD_W{1'b0}}, ctrl};
      A_PER:    rd_mux = per_act;
      A_CMP:    rd_mux = cmp_act;
      A_PER_SH: rd_mux = per_sh;
      A_CMP_SH: rd_mux = cmp_sh;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R6
  shadow_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (per_act == $past(per_sh)) && (cmp_act == $past(cmp_sh)));

  // R7
  active_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(per_act) && $stable(cmp_act));
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = run && (cnt >= per);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (run)  cnt <= cnt + 1'b1;
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt >= per) |=> (cnt == '0));
endmodule

// File: rtl/apwm_outgen.sv
module apwm_outgen #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] per,
  output logic             pwm_out
);
  logic hi_phase;

  assign hi_phase = (cnt < cmp) || (cmp >= per);

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= mode ? (hi_phase ^ pol) : 1'b0;
  end

  // R4
  mode_low_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !pwm_out);

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && !pol && cmp == '0 && per != '0) |=> !pwm_out);
endmodule

// File: rtl/apwm_shadow_pwm.sv
module apwm_shadow_pwm
  import apwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              pwm_out
);
  logic             run, mode, pol, wrap;
  logic [CNT_W-1:0] per_act, cmp_act, cnt;

  apwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .wrap(wrap), .run(run), .mode(mode), .pol(pol),
    .per_act(per_act), .cmp_act(cmp_act), .rdata(reg_rdata)
  );

  apwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .per(per_act), .cnt(cnt), .wrap(wrap)
  );

  apwm_outgen #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .mode(mode), .pol(pol), .cnt(cnt),
    .cmp(cmp_act), .per(per_act), .pwm_out(pwm_out)
  );
endmodule

// File: tb/tb_apwm_shadow_pwm.sv
module tb_apwm_shadow_pwm;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             pwm_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string req;
    logic  val;
  } exp_t;
  exp_t q[$];

  apwm_shadow_pwm #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // monitor: one expected output sample per clock
  always begin
    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwm_out !== e.val) begin
        errors++;
        $display("FAIL %s pwm_out actual=%b expected=%b", e.req, pwm_out, e.val);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic push(string req, logic v, int n);
    for (int i = 0; i < n; i++) q.push_back('{req, v});
  endtask

  task automatic push_pat(string req, logic [7:0] pat, int len, int reps);
    for (int r = 0; r < reps; r++)
      for (int i = len - 1; i >= 0; i--) q.push_back('{req, pat[i]});
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [CNT_W-1:0] exp, string req);
    reg_addr = a;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata[%0d] actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(int per, int cmp, int per_sh, int cmp_sh);
    wr(3'd1, per); wr(3'd2, cmp); wr(3'd3, per_sh); wr(3'd4, cmp_sh);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 pwm_out actual=%b expected=0", pwm_out);
    end
    for (int a = 0; a < 5; a++) rd_chk(a[2:0], '0, "R1");

    // R9 / R10: readback, upper control bits dropped, sync bits stored
    wr(3'd0, 32'hABCD_00C0);
    load(32'hA5A5_0001, 32'hA5A5_0002, 32'hA5A5_0003, 32'hA5A5_0004);
    rd_chk(3'd0, 32'h0000_00C0, "R10");
    rd_chk(3'd1, 32'hA5A5_0001, "R7");
    rd_chk(3'd2, 32'hA5A5_0002, "R9");
    rd_chk(3'd3, 32'hA5A5_0003, "R9");
    rd_chk(3'd4, 32'hA5A5_0004, "R9");
    rd_chk(3'd5, '0, "R9");
    rd_chk(3'd7, '0, "R9");

    // R2: normal polarity, period 4 (5 clocks), compare 2; sync bits set (R10)
    do_reset();
    load(4, 2, 4, 2);
    wr(3'd0, 32'h0000_02D0);
    push("R2", 1'b0, 1);
    push_pat("R2", 8'b0001_1000, 5, 3);
    drain();

    // R3: inverted polarity
    do_reset();
    load(4, 2, 4, 2);
    wr(3'd0, 32'h0000_0610);
    push("R3", 1'b0, 1);
    push_pat("R3", 8'b0000_0111, 5, 2);
    drain();

    // R4: run without mode keeps the pin low
    do_reset();
    load(4, 2, 4, 2);
    wr(3'd0, 32'h0000_0010);
    push("R4", 1'b0, 12);
    drain();

    // R5: stop the counter at value 1 while mode stays on
    do_reset();
    load(4, 2, 4, 2);
    wr(3'd0, 32'h0000_0210);
    push("R5", 1'b0, 1);
    push("R5", 1'b1, 10);
    wr(3'd0, 32'h0000_0200);
    drain();

    // R6: staging written mid-cycle, applied only at the wrap
    do_reset();
    load(4, 1, 4, 1);
    wr(3'd0, 32'h0000_0210);
    push("R6", 1'b0, 1);
    push_pat("R6", 8'b0001_0000, 5, 1);
    push_pat("R6", 8'b0000_1100, 4, 2);
    wr(3'd3, 3);
    wr(3'd4, 2);
    drain();
    rd_chk(3'd1, 3, "R6");
    rd_chk(3'd2, 2, "R6");

    // R7: direct live writes ignored while running
    wr(3'd2, 7);
    wr(3'd1, 9);
    rd_chk(3'd2, 2, "R7");
    rd_chk(3'd1, 3, "R7");

    // R8: compare 0 gives constant low
    do_reset();
    load(4, 0, 4, 0);
    wr(3'd0, 32'h0000_0210);
    push("R8", 1'b0, 12);
    drain();

    // R8: compare equal to period gives constant high
    do_reset();
    load(4, 4, 4, 4);
    wr(3'd0, 32'h0000_0210);
    push("R8", 1'b0, 1);
    push("R8", 1'b1, 11);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule